// File: doc/BRIEF.md
# Program Counter Sequencer

This block produces the instruction fetch address for a small scalar core with separate instruction and data memories. It holds a 12-bit byte address into a 4 KB instruction store. On every cycle that is not held, it moves to the next word. If a redirect was requested earlier, it loads that target instead. The byte offset inside a word is always zero. Any address bits beyond the 4 KB window are discarded. Running past the last word at 0xFFC continues at 0x000.

The decode/execute stage resolves all branch conditions and presents only the outcome. It gives a taken-branch strobe with its target, or a register-jump strobe with its target. An accepted request always executes exactly one delay-slot instruction first, and that instruction is never annulled. The block has no exception or trap vectors, so the address only ever changes by sequential advance or by a requested target. For jump-and-link, the block also offers a link address equal to the current fetch address plus eight, with the same 12-bit wrap.

Top module: `pc_sequencer`

## Requirements
- R1: While `rst_i` is high at a clock edge, `fetch_pc_o` becomes 0x000 and `dslot_o` becomes 0. Any pending redirect is discarded.
- R2: On a cycle with `hold_i` low and `dslot_o` low, `fetch_pc_o` advances by 4 modulo 4096 at the next edge, so 0xFFC is followed by 0x000.
- R3: On a cycle with `hold_i` high, `fetch_pc_o` and `dslot_o` keep their values and any request on that cycle is ignored. A held delay slot keeps its stored target.
- R4: A request accepted on a cycle with `hold_i` low and `dslot_o` low is followed by exactly one fetch at the current address plus 4, with `dslot_o` high. The next unheld edge then loads the requested target.
- R5: The loaded target is `tgt & 0xFFC`: bits 31..12 are dropped and bits 1..0 are cleared.
- R6: When `jr_take_i` and `br_take_i` are both accepted on the same cycle, `jr_tgt_i` is used.
- R7: Requests presented on an unheld cycle where `dslot_o` is high are ignored. After that cycle `dslot_o` is low.
- R8: `link_pc_o` always equals (`fetch_pc_o` + 8) modulo 4096.
- R9: Bits 1..0 of `fetch_pc_o` are always zero.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_i | input | 1 | Synchronous reset, active high |
| hold_i | input | 1 | Stall/halt: freeze the sequencer |
| br_take_i | input | 1 | Resolved taken-branch strobe |
| br_tgt_i | input | 32 | Branch target address |
| jr_take_i | input | 1 | Register-jump strobe |
| jr_tgt_i | input | 32 | Register-jump target address |
| fetch_pc_o | output | 12 | Instruction fetch byte address |
| link_pc_o | output | 12 | Return address (fetch + 8, wrapped) |
| dslot_o | output | 1 | Current fetch is a delay slot |

## Verification
The clocked properties assume the control inputs are 0 or 1 on every edge after reset and never unknown. The stepping property assumes the previous cycle's hold and slot state fully decide the next address. The bench drives all inputs from a task on the falling edge, so every edge sees settled and defined values. The random stimulus includes strobes asserted during holds, strobes asserted during delay slots, and both strobes at once. Targets carry bits set outside the 12-bit word-aligned window.

// File: rtl/pcseq_pkg.sv
package pcseq_pkg;
  // Byte-address width of the instruction store (4 KB)
  localparam int unsigned PC_W    = 12;
  // Bytes per instruction as a power of two
  localparam int unsigned ALIGN_B = 2;
  // Width of targets handed over by the execute stage
  localparam int unsigned TGT_W   = 32;
  localparam int unsigned STEP    = 1 << ALIGN_B;

  typedef logic [PC_W-1:0]  pc_t;
  typedef logic [TGT_W-1:0] tgt_t;

  localparam pc_t WORD_MASK = pc_t'(~((1 << ALIGN_B) - 1));

  // Cut a wide target to the fetch window and word alignment
  function automatic pc_t fit_target(input tgt_t t);
    pc_t low;
    low = t[PC_W-1:0];
    return low & WORD_MASK;
  endfunction

  // Add a small byte offset with modulo-window wrap
  function automatic pc_t wrap_add(input pc_t a, input int unsigned n);
    pc_t inc;
    inc = pc_t'(n);
    return a + inc;
  endfunction
endpackage

// File: rtl/pcseq_target_sel.sv
module pcseq_target_sel
  import pcseq_pkg::*;
#(
  parameter bit JR_FIRST = 1'b1
) (
  input  logic br_take_i,
  input  tgt_t br_tgt_i,
  input  logic jr_take_i,
  input  tgt_t jr_tgt_i,
  output logic req_o,
  output pc_t  tgt_o
);
  pc_t br_fit_w;
  pc_t jr_fit_w;

  assign br_fit_w = fit_target(br_tgt_i);
  assign jr_fit_w = fit_target(jr_tgt_i);
  assign req_o    = br_take_i | jr_take_i;

  generate
    if (JR_FIRST) begin : g_jr_first
      always_comb tgt_o = jr_take_i ? jr_fit_w : br_fit_w;
    end else begin : g_br_first
      always_comb tgt_o = br_take_i ? br_fit_w : jr_fit_w;
    end
  endgenerate
endmodule

// File: rtl/pcseq_slot_reg.sv
module pcseq_slot_reg
  import pcseq_pkg::*;
(
  input  logic clk_i,
  input  logic rst_i,
  input  logic adv_i,
  input  logic req_i,
  input  pc_t  tgt_i,
  output logic slot_o,
  output pc_t  slot_tgt_o
);
  logic accept_w;
  logic retire_w;

  assign accept_w = adv_i & ~slot_o & req_i;
  assign retire_w = adv_i & slot_o;

  always_ff @(posedge clk_i) begin
    if (rst_i) begin
      slot_o     <= 1'b0;
      slot_tgt_o <= '0;
    end else if (retire_w) begin
      slot_o     <= 1'b0;
    end else if (accept_w) begin
      slot_o     <= 1'b1;
      slot_tgt_o <= tgt_i;
    end
  end

  // R4
  accept_opens_slot_chk: assert property (@(posedge clk_i) disable iff (rst_i)
    (adv_i && !slot_o && req_i) |=> slot_o);

  // R7
  slot_closes_chk: assert property (@(posedge clk_i) disable iff (rst_i)
    (adv_i && slot_o) |=> !slot_o);

  // R3
  slot_hold_chk: assert property (@(posedge clk_i) disable iff (rst_i)
    !adv_i |=> ($stable(slot_o) && $stable(slot_tgt_o)));
endmodule

// File: rtl/pcseq_pc_reg.sv
module pcseq_pc_reg
  import pcseq_pkg::*;
(
  input  logic clk_i,
  input  logic rst_i,
  input  logic adv_i,
  input  logic load_i,
  input  pc_t  load_pc_i,
  output pc_t  pc_o,
  output pc_t  link_o
);
  pc_t seq_pc_w;
  pc_t next_pc_w;

  assign seq_pc_w  = wrap_add(pc_o, STEP);
  assign next_pc_w = load_i ? load_pc_i : seq_pc_w;
  assign link_o    = wrap_add(pc_o, 2 * STEP);

  always_ff @(posedge clk_i) begin
    if (rst_i)      pc_o <= '0;
    else if (adv_i) pc_o <= next_pc_w;
  end

  // R3
  pc_hold_chk: assert property (@(posedge clk_i) disable iff (rst_i)
    !adv_i |=> $stable(pc_o));

  // R2
  pc_step_chk: assert property (@(posedge clk_i) disable iff (rst_i)
    (adv_i && !load_i) |=> (pc_o == PC_W'($past(pc_o) + PC_W'(STEP))));

  // R9
  pc_align_chk: assert property (@(posedge clk_i) disable iff (rst_i)
    pc_o[ALIGN_B-1:0] == '0);
endmodule

// File: rtl/pc_sequencer.sv
module pc_sequencer
  import pcseq_pkg::*;
(
  input  logic        clk_i,
  input  logic        rst_i,
  input  logic        hold_i,
  input  logic        br_take_i,
  input  logic [31:0] br_tgt_i,
  input  logic        jr_take_i,
  input  logic [31:0] jr_tgt_i,
  output logic [11:0] fetch_pc_o,
  output logic [11:0] link_pc_o,
  output logic        dslot_o
);
  logic adv_w;
  logic req_w;
  pc_t  sel_tgt_w;
  logic slot_w;
  pc_t  slot_tgt_w;
  pc_t  pc_w;
  pc_t  link_w;

  assign adv_w = ~hold_i;

  pcseq_target_sel #(.JR_FIRST(1'b1)) sel_i (
    .br_take_i (br_take_i),
    .br_tgt_i  (br_tgt_i),
    .jr_take_i (jr_take_i),
    .jr_tgt_i  (jr_tgt_i),
    .req_o     (req_w),
    .tgt_o     (sel_tgt_w)
  );

  pcseq_slot_reg slot_i (
    .clk_i      (clk_i),
    .rst_i      (rst_i),
    .adv_i      (adv_w),
    .req_i      (req_w),
    .tgt_i      (sel_tgt_w),
    .slot_o     (slot_w),
    .slot_tgt_o (slot_tgt_w)
  );

  pcseq_pc_reg pc_i (
    .clk_i     (clk_i),
    .rst_i     (rst_i),
    .adv_i     (adv_w),
    .load_i    (slot_w),
    .load_pc_i (slot_tgt_w),
    .pc_o      (pc_w),
    .link_o    (link_w)
  );

  assign fetch_pc_o = pc_w;
  assign link_pc_o  = link_w;
  assign dslot_o    = slot_w;

  // R4
  slot_loads_target_chk: assert property (@(posedge clk_i) disable iff (rst_i)
    (!hold_i && slot_w) |=> (fetch_pc_o == $past(slot_tgt_w)));
endmodule

// File: tb/pc_sequencer_tb_top.sv
module pc_sequencer_tb_top;
  logic        clk = 1'b0;
  logic        rst;
  logic        hold;
  logic        br_t;
  logic [31:0] br_a;
  logic        jr_t;
  logic [31:0] jr_a;
  logic [11:0] fetch_pc;
  logic [11:0] link_pc;
  logic        dslot;

  int checks = 0;
  int errors = 0;

  int m_pc;
  int m_pend;
  int m_tgt;

  always #4 clk = ~clk;

  pc_sequencer dut_i (
    .clk_i(clk), .rst_i(rst), .hold_i(hold),
    .br_take_i(br_t), .br_tgt_i(br_a),
    .jr_take_i(jr_t), .jr_tgt_i(jr_a),
    .fetch_pc_o(fetch_pc), .link_pc_o(link_pc), .dslot_o(dslot)
  );

  task automatic chk(input string tag, input int act, input int exp);
    checks++;
    if (act != exp) begin
      errors++;
      $display("FAIL %s actual=%0h expected=%0h", tag, act, exp);
    end
  endtask

  task automatic compare(input string tag);
    chk({tag, " fetch"}, int'(fetch_pc), m_pc);
    chk({tag, " slot"}, int'(dslot), m_pend);
    chk("R8 link", int'(link_pc), (m_pc + 8) % 4096);
    chk("R9 align", int'(fetch_pc) % 4, 0);
  endtask

  // Drive one cycle from just after a falling edge; compare at the next one
  task automatic step(input string tag, input bit h, input bit b, input int ba,
                      input bit j, input int ja);
    hold = h; br_t = b; br_a = ba; jr_t = j; jr_a = ja;
    if (!h) begin
      if (m_pend != 0) begin
        m_pc = m_tgt;
        m_pend = 0;
      end else begin
        if (b || j) begin
          m_tgt = (j ? ja : ba) & 32'hFFC;
          m_pend = 1;
        end
        m_pc = (m_pc + 4) % 4096;
      end
    end
    @(negedge clk);
    compare(tag);
  endtask

  initial begin
    repeat (150000) @(posedge clk);
    checks++;
    errors++;
    $display("FAIL watchdog actual=running expected=done");
    $display("  CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end

  initial begin
    rst = 1; hold = 0; br_t = 0; br_a = 0; jr_t = 0; jr_a = 0;
    m_pc = 0; m_pend = 0; m_tgt = 0;
    @(negedge clk);
    @(negedge clk);
    compare("R1 reset");
    rst = 0;

    // R2 plain stepping
    for (int i = 0; i < 3; i++) step("R2 seq", 0, 0, 0, 0, 0);
    // R3 hold with a request present
    step("R3 hold", 1, 1, 32'h100, 0, 0);
    step("R3 hold", 1, 0, 0, 1, 32'h200);
    // R4/R5: jump with junk high and low bits
    step("R4 accept", 0, 0, 0, 1, 32'h7FFF_FFFB);
    chk("R4 delay slot", int'(dslot), 1);
    // R7: request inside slot ignored
    step("R7 ignore", 0, 1, 32'h0400, 0, 0);
    chk("R5 masked target", int'(fetch_pc), 12'hFF8);
    step("R2 seq", 0, 0, 0, 0, 0);
    chk("R2 last word", int'(fetch_pc), 12'hFFC);
    step("R2 wrap", 0, 0, 0, 0, 0);
    chk("R2 wrap to zero", int'(fetch_pc), 0);
    // R6 both strobes
    step("R6 both", 0, 1, 32'h0123_0040, 1, 32'h0000_0A82);
    step("R6 both", 0, 0, 0, 0, 0);
    chk("R6 jr wins", int'(fetch_pc), 12'hA80);
    // R3 hold inside a delay slot keeps target
    step("R4 accept", 0, 1, 32'hFFFF_F30C, 0, 0);
    step("R3 hold slot", 1, 0, 0, 1, 32'h50);
    chk("R3 slot held", int'(dslot), 1);
    step("R5 load", 0, 0, 0, 0, 0);
    chk("R5 branch target", int'(fetch_pc), 12'h30C);

    // Random traffic
    for (int i = 0; i < 3000; i++) begin
      step("R4 random", ($urandom % 4) == 0, ($urandom % 5) == 0, int'($urandom),
           ($urandom % 7) == 0, int'($urandom));
    end

    // R1 reset with a pending slot
    step("R4 accept", 0, 1, 32'h444, 0, 0);
    rst = 1;
    @(negedge clk);
    rst = 0;
    m_pc = 0; m_pend = 0;
    compare("R1 mid reset");
    step("R1 no stale target", 0, 0, 0, 0, 0);
    chk("R1 after reset", int'(fetch_pc), 4);

    $display("  CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end
endmodule